// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides, for an I2C slave, whether the address phase of a transfer is meant for it. A byte-level receiver in front of it delivers each received byte with a strobe. It also sends separate strobes for a start, a repeated start and a stop condition. The matcher compares the address bytes with the slave's configured addresses. It drives the acknowledge for each address byte and reports when the address phase has ended in a match. With a match it gives the transfer direction and a 7-bit code that names the address that was hit.

There are two own addresses. The first is either a 7-bit or a 10-bit address, chosen by a mode input. The second is a 7-bit address whose low bits can be masked. Four fixed reserved addresses can each be enabled on their own: general call, bus alert response, device default and bus host.

A 10-bit write is taken in two steps: the header byte, then the low address byte. A 10-bit read is taken by a repeated start followed by the read header. It is accepted only while the slave still owns the transfer from a completed 10-bit write. Bit shifting, clock stretching and data bytes are handled elsewhere.

Top module: `i2c_addr_match`

## Requirements
- R1: Reset clears `match_o`, `ack_o`, `dir_o` and `code_o` to zero. Address bytes that arrive after reset and before the first start strobe are ignored.
- R2: `match_o` and `ack_o` are one-cycle pulses in the cycle after the `byte_stb` that caused them. `match_o` is never high without `ack_o`. `dir_o` and `code_o` change only together with a `match_o` pulse and hold their value otherwise.
- R3: Own address 1 in 7-bit mode (`own1_ten`=0) matches when `own1_en` is set and the received byte bits 7:1 equal `own1_addr[6:0]`.
- R4: Own address 2 compares the 7-bit address with `own2_addr`, ignoring the n least significant address bits, where n = `own2_mask` (0..6). With a mask value of 7, every address matches. Own address 2 never matches a reserved address (top four bits 0000 or 1111).
- R5: Each reserved address is matched only while its enable is set: 0000000 (`gcall_en`), 0001100 (`alert_en`), 1100001 (`dflt_en`) and 0001000 (`host_en`).
- R6: On a 7-bit match, `code_o` is the received address (byte bits 7:1) and `dir_o` is the received byte bit 0.
- R7: In 10-bit mode, a first byte of the form 11110 `own1_addr[9:8]` 0 is acknowledged without a match. If the next byte equals `own1_addr[7:0]`, it is acknowledged with a match, `dir_o`=0 and `code_o` = 11110 `own1_addr[9:8]`. If it differs, it is not acknowledged and there is no match.
- R8: After a completed 10-bit write, a repeated start followed by the read header 11110 `own1_addr[9:8]` 1 gives acknowledge, match, `dir_o`=1 and `code_o` = 11110 `own1_addr[9:8]`. The same read header after a plain start is not acknowledged.
- R9: A start or a stop strobe discards a pending 10-bit header and any 10-bit ownership. Bytes after a stop, or after the address phase has ended, are ignored until the next start or repeated start.
- R10: The code of a 10-bit match is always 11110 `own1_addr[9:8]`, even when `own1_addr[7:1]` equals an enabled 7-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_stb | input | 1 | Start condition seen |
| rstart_stb | input | 1 | Repeated start condition seen |
| stop_stb | input | 1 | Stop condition seen |
| byte_stb | input | 1 | A received byte is valid on `byte_data` |
| byte_data | input | 8 | Received byte, R/W bit in bit 0 |
| own1_addr | input | 10 | Own address 1 (bits 6:0 used in 7-bit mode) |
| own1_en | input | 1 | Enable own address 1 |
| own1_ten | input | 1 | Own address 1 is a 10-bit address |
| own2_addr | input | 7 | Own address 2 |
| own2_mask | input | 3 | Count of low bits of own address 2 to ignore; 7 = any |
| own2_en | input | 1 | Enable own address 2 |
| gcall_en | input | 1 | Enable general call address |
| alert_en | input | 1 | Enable alert response address |
| dflt_en | input | 1 | Enable device default address |
| host_en | input | 1 | Enable host address |
| match_o | output | 1 | Address phase ended in a match (pulse) |
| ack_o | output | 1 | Acknowledge the last address byte (pulse) |
| dir_o | output | 1 | Direction of the matched transfer, 1 = slave transmits |
| code_o | output | 7 | Code of the matched address |

## Verification
The checks assume that at most one of the four strobes is high in any cycle. They also assume that the configuration inputs hold steady for the whole of a transfer, from its start to its stop. The bench pulses each strobe for one cycle, with idle cycles in between. It changes the enables, modes and addresses only while no address phase is pending. A behavioural model in the bench, built on integer arithmetic, predicts every output on every clock from the same inputs.

// File: rtl/i2c_am_pkg.sv
// Shared widths, phase encoding and reserved address lookup for the
// I2C address matcher. Assumes byte-wide address delivery.
package i2c_am_pkg;
    localparam int BYTE_W  = 8;
    localparam int A7_W    = 7;
    localparam int A10_W   = 10;
    localparam int MSK_W   = 3;
    localparam int HDR_W   = 5;
    localparam int HI_W    = A10_W - BYTE_W;
    localparam int RSV_N   = 4;
    localparam logic [HDR_W-1:0] HDR_TAG = 5'b11110;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // bytes are ignored
        PH_FIRST = 2'd1,   // next byte is the first address byte
        PH_LOW   = 2'd2    // next byte is the low 10-bit address byte
    } phase_t;

    // Reserved 7-bit addresses, indexed like the rsv_on vector.
    function automatic logic [A7_W-1:0] rsv_addr(input int idx);
        case (idx)
            0:       rsv_addr = 7'b0000000;  // general call
            1:       rsv_addr = 7'b0001100;  // alert response
            2:       rsv_addr = 7'b1100001;  // device default
            default: rsv_addr = 7'b0001000;  // host
        endcase
    endfunction
endpackage

// File: rtl/i2c_am_seven_cmp.sv
// Combinational 7-bit address compare: own address 1 (exact), own
// address 2 (masked low bits, never reserved) and the enabled reserved
// addresses. Assumes the caller has already excluded 10-bit headers.
module i2c_am_seven_cmp
    import i2c_am_pkg::*;
(
    input  logic [A7_W-1:0]  rx_addr,
    input  logic [A7_W-1:0]  own1,
    input  logic             own1_on,
    input  logic [A7_W-1:0]  own2,
    input  logic [MSK_W-1:0] own2_msk,
    input  logic             own2_on,
    input  logic [RSV_N-1:0] rsv_on,
    output logic             any_hit
);
    logic [A7_W-1:0]  care;
    logic [RSV_N-1:0] rsv_hit;
    logic             is_rsv;
    logic             own1_hit;
    logic             own2_hit;

    // Bit i of own address 2 is compared only when i is at or above the mask.
    for (genvar i = 0; i < A7_W; i++) begin : g_care
        assign care[i] = (MSK_W'(i) >= own2_msk);
    end

    // One comparator per reserved address, gated by its enable.
    for (genvar r = 0; r < RSV_N; r++) begin : g_rsv
        assign rsv_hit[r] = rsv_on[r] && (rx_addr == rsv_addr(r));
    end

    // Merge the individual address hits.
    always_comb begin
        is_rsv   = (rx_addr[A7_W-1 -: 4] == 4'b0000) || (rx_addr[A7_W-1 -: 4] == 4'b1111);
        own1_hit = own1_on && (rx_addr == own1);
        own2_hit = own2_on && !is_rsv && (((rx_addr ^ own2) & care) == '0);
        any_hit  = own1_hit || own2_hit || (|rsv_hit);
    end
endmodule

// File: rtl/i2c_am_ten_cmp.sv
// Combinational 10-bit address helpers: header form check against the
// two high own-address bits, and low-byte compare.
module i2c_am_ten_cmp
    import i2c_am_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [A10_W-1:0]  own1,
    output logic              hdr_hit,
    output logic              lo_hit,
    output logic [A7_W-1:0]   ten_code
);
    // Header form, low byte equality and the code reported on a 10-bit hit.
    always_comb begin
        hdr_hit  = (rx_byte[BYTE_W-1 -: HDR_W] == HDR_TAG) &&
                   (rx_byte[HI_W:1] == own1[A10_W-1 -: HI_W]);
        lo_hit   = (rx_byte == own1[BYTE_W-1:0]);
        ten_code = {HDR_TAG, own1[A10_W-1 -: HI_W]};
    end
endmodule

// File: rtl/i2c_addr_match.sv
// I2C slave address matcher. Tracks the address phase between start,
// repeated start and stop strobes, acknowledges address bytes and reports
// match, direction and match code one cycle after each byte strobe.
// Assumes at most one strobe per cycle and stable configuration per transfer.
module i2c_addr_match
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_stb,
    input  logic              rstart_stb,
    input  logic              stop_stb,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [A10_W-1:0]  own1_addr,
    input  logic              own1_en,
    input  logic              own1_ten,
    input  logic [A7_W-1:0]   own2_addr,
    input  logic [MSK_W-1:0]  own2_mask,
    input  logic              own2_en,
    input  logic              gcall_en,
    input  logic              alert_en,
    input  logic              dflt_en,
    input  logic              host_en,
    output logic              match_o,
    output logic              ack_o,
    output logic              dir_o,
    output logic [A7_W-1:0]   code_o
);
    phase_t          phase_q, phase_d;
    logic            owned_q, owned_d;
    logic            match_d, ack_d, dir_d;
    logic [A7_W-1:0] code_d;
    logic            seven_hit, hdr_hit, lo_hit, ten_on;
    logic [A7_W-1:0] ten_code;

    i2c_am_seven_cmp u_seven (
        .rx_addr  (byte_data[BYTE_W-1:1]),
        .own1     (own1_addr[A7_W-1:0]),
        .own1_on  (own1_en && !own1_ten),
        .own2     (own2_addr),
        .own2_msk (own2_mask),
        .own2_on  (own2_en),
        .rsv_on   ({host_en, dflt_en, alert_en, gcall_en}),
        .any_hit  (seven_hit)
    );

    i2c_am_ten_cmp u_ten (
        .rx_byte  (byte_data),
        .own1     (own1_addr),
        .hdr_hit  (hdr_hit),
        .lo_hit   (lo_hit),
        .ten_code (ten_code)
    );

    assign ten_on = own1_en && own1_ten;

    // Next-state and output decision for the current strobe.
    always_comb begin
        phase_d = phase_q;
        owned_d = owned_q;
        match_d = 1'b0;
        ack_d   = 1'b0;
        dir_d   = dir_o;
        code_d  = code_o;
        if (stop_stb) begin
            phase_d = PH_IDLE;
            owned_d = 1'b0;
        end else if (start_stb) begin
            phase_d = PH_FIRST;
            owned_d = 1'b0;
        end else if (rstart_stb) begin
            phase_d = PH_FIRST;
        end else if (byte_stb) begin
            case (phase_q)
                PH_FIRST: begin
                    phase_d = PH_IDLE;
                    if (ten_on && hdr_hit) begin
                        if (!byte_data[0]) begin
                            ack_d   = 1'b1;
                            phase_d = PH_LOW;
                        end else if (owned_q) begin
                            ack_d   = 1'b1;
                            match_d = 1'b1;
                            dir_d   = 1'b1;
                            code_d  = ten_code;
                        end
                    end else if (seven_hit) begin
                        ack_d   = 1'b1;
                        match_d = 1'b1;
                        dir_d   = byte_data[0];
                        code_d  = byte_data[BYTE_W-1:1];
                    end
                end
                PH_LOW: begin
                    phase_d = PH_IDLE;
                    if (ten_on && lo_hit) begin
                        ack_d   = 1'b1;
                        match_d = 1'b1;
                        dir_d   = 1'b0;
                        code_d  = ten_code;
                        owned_d = 1'b1;
                    end else begin
                        owned_d = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // State and output registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            owned_q <= 1'b0;
            match_o <= 1'b0;
            ack_o   <= 1'b0;
            dir_o   <= 1'b0;
            code_o  <= '0;
        end else begin
            phase_q <= phase_d;
            owned_q <= owned_d;
            match_o <= match_d;
            ack_o   <= ack_d;
            dir_o   <= dir_d;
            code_o  <= code_d;
        end
    end
endmodule

// File: rtl/i2c_am_chk.sv
// Property checker for the I2C address matcher, bound to the top module.
// Assumes one strobe per cycle and configuration stable per transfer.
module i2c_am_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_stb,
    input logic       byte_stb,
    input logic [7:0] byte_data,
    input logic       own1_en,
    input logic       own2_en,
    input logic       gcall_en,
    input logic       match_o,
    input logic       ack_o,
    input logic       dir_o,
    input logic [6:0] code_o
);
    // R2
    match_has_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> ack_o);

    // R2
    ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(byte_stb));

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_o |-> ($stable(dir_o) && $stable(code_o)));

    // R5
    gcall_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && byte_data[7:1] == 7'd0 && !gcall_en && !own1_en && !own2_en) |=> !match_o);

    // R9
    after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && $past(stop_stb)) |=> !ack_o);
endmodule

bind i2c_addr_match i2c_am_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_stb  (stop_stb),
    .byte_stb  (byte_stb),
    .byte_data (byte_data),
    .own1_en   (own1_en),
    .own2_en   (own2_en),
    .gcall_en  (gcall_en),
    .match_o   (match_o),
    .ack_o     (ack_o),
    .dir_o     (dir_o),
    .code_o    (code_o)
);

// File: tb/i2c_addr_match_test.sv
// Bench for the I2C address matcher: directed checks plus a behavioural
// model compared on every clock.
module i2c_addr_match_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_stb = 1'b0, rstart_stb = 1'b0, stop_stb = 1'b0, byte_stb = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic [9:0] own1_addr = 10'h021;
    logic       own1_en = 1'b0, own1_ten = 1'b0;
    logic [6:0] own2_addr = 7'h00;
    logic [2:0] own2_mask = 3'd0;
    logic       own2_en = 1'b0, gcall_en = 1'b0, alert_en = 1'b0, dflt_en = 1'b0, host_en = 1'b0;
    logic       match_o, ack_o, dir_o;
    logic [6:0] code_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // Model state
    int m_ph = 0;
    bit m_own = 0;
    bit e_hit = 0, e_ack = 0, e_dir = 0;
    int e_code = 0;

    always #5 clk = ~clk;

    i2c_addr_match uut (
        .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .rstart_stb(rstart_stb),
        .stop_stb(stop_stb), .byte_stb(byte_stb), .byte_data(byte_data),
        .own1_addr(own1_addr), .own1_en(own1_en), .own1_ten(own1_ten),
        .own2_addr(own2_addr), .own2_mask(own2_mask), .own2_en(own2_en),
        .gcall_en(gcall_en), .alert_en(alert_en), .dflt_en(dflt_en), .host_en(host_en),
        .match_o(match_o), .ack_o(ack_o), .dir_o(dir_o), .code_o(code_o)
    );

    function automatic bit m_hit7(int a);
        bit rsv = (a < 8) || (a >= 120);
        int sh = int'(own2_mask);
        bit h = 0;
        if (own1_en && !own1_ten && a == int'(own1_addr[6:0])) h = 1;
        if (own2_en && !rsv && (sh == 7 || (a >> sh) == (int'(own2_addr) >> sh))) h = 1;
        if (gcall_en && a == 0)  h = 1;
        if (alert_en && a == 12) h = 1;
        if (dflt_en && a == 97)  h = 1;
        if (host_en && a == 8)   h = 1;
        return h;
    endfunction

    // Behavioural model, advanced on every rising edge.
    always @(posedge clk) begin
        int b, hi;
        if (!rst_n) begin
            m_ph = 0; m_own = 0; e_hit = 0; e_ack = 0; e_dir = 0; e_code = 0;
        end else begin
            e_hit = 0; e_ack = 0;
            b  = int'(byte_data);
            hi = int'(own1_addr) / 256;
            if (stop_stb) begin m_ph = 0; m_own = 0; end
            else if (start_stb) begin m_ph = 1; m_own = 0; end
            else if (rstart_stb) m_ph = 1;
            else if (byte_stb) begin
                if (m_ph == 1) begin
                    m_ph = 0;
                    if (own1_en && own1_ten && b / 8 == 30 && (b / 2) % 4 == hi) begin
                        if (b % 2 == 0) begin e_ack = 1; m_ph = 2; end
                        else if (m_own) begin e_ack = 1; e_hit = 1; e_dir = 1; e_code = 120 + hi; end
                    end else if (m_hit7(b / 2)) begin
                        e_ack = 1; e_hit = 1; e_dir = b % 2; e_code = b / 2;
                    end
                end else if (m_ph == 2) begin
                    m_ph = 0;
                    if (own1_en && own1_ten && b == int'(own1_addr) % 256) begin
                        e_ack = 1; e_hit = 1; e_dir = 0; e_code = 120 + hi; m_own = 1;
                    end else m_own = 0;
                end
            end
        end
    end

    // Per-cycle comparison against the model (R2 timing and hold).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (match_o !== e_hit || ack_o !== e_ack || dir_o !== e_dir || int'(code_o) != e_code) begin
                fails++;
                $display("FAIL R2 model: got m%0b a%0b d%0b c%02h exp m%0b a%0b d%0b c%02h",
                         match_o, ack_o, dir_o, code_o, e_hit, e_ack, e_dir, e_code);
            end
        end
    end

    task automatic chk(string req, bit cond, int got, int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_stb = 1'b1; @(negedge clk); start_stb = 1'b0;
    endtask
    task automatic pulse_rstart();
        @(negedge clk); rstart_stb = 1'b1; @(negedge clk); rstart_stb = 1'b0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); stop_stb = 1'b1; @(negedge clk); stop_stb = 1'b0;
    endtask

    // Sends one byte and checks ack and match in the following cycle.
    task automatic send(string req, logic [7:0] b, bit eack, bit ehit);
        @(negedge clk); byte_stb = 1'b1; byte_data = b;
        @(negedge clk); byte_stb = 1'b0;
        chk(req, ack_o === eack, {ack_o}, {eack});
        chk(req, match_o === ehit, {match_o}, {ehit});
    endtask

    task automatic result(string req, bit ed, logic [6:0] ec);
        chk(req, dir_o === ed, {dir_o}, {ed});
        chk(req, code_o === ec, int'(code_o), int'(ec));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", match_o === 0 && ack_o === 0, {match_o, ack_o}, 0);
        result("R1", 0, 7'h00);
        own1_en = 1; own1_ten = 0; own1_addr = 10'h021;
        send("R1", 8'h42, 0, 0);             // before any start: ignored

        // R3 / R6 7-bit own address 1
        pulse_start();
        send("R3", 8'h42, 1, 1);
        result("R6", 0, 7'h21);
        send("R9", 8'h42, 0, 0);             // data phase byte ignored
        result("R2", 0, 7'h21);
        pulse_stop();
        pulse_start();
        send("R6", 8'h43, 1, 1);
        result("R6", 1, 7'h21);
        pulse_start();
        send("R3", 8'h44, 0, 0);
        result("R2", 1, 7'h21);

        // R4 masked own address 2
        own2_en = 1; own2_addr = 7'h50; own2_mask = 3'd2;
        pulse_start(); send("R4", 8'hA6, 1, 1); result("R4", 0, 7'h53);
        pulse_start(); send("R4", 8'hAE, 0, 0);
        own2_mask = 3'd7;
        pulse_start(); send("R4", 8'h66, 1, 1); result("R4", 0, 7'h33);
        pulse_start(); send("R4", 8'hF4, 0, 0);
        pulse_start(); send("R4", 8'h06, 0, 0);
        own2_en = 0; own2_mask = 3'd0;

        // R5 reserved addresses
        pulse_start(); send("R5", 8'h00, 0, 0);
        gcall_en = 1;
        pulse_start(); send("R5", 8'h00, 1, 1); result("R5", 0, 7'h00);
        alert_en = 1;
        pulse_start(); send("R5", 8'h19, 1, 1); result("R5", 1, 7'h0C);
        pulse_start(); send("R5", 8'h10, 0, 0);
        host_en = 1;
        pulse_start(); send("R5", 8'h10, 1, 1); result("R5", 0, 7'h08);
        pulse_start(); send("R5", 8'hC2, 0, 0);
        dflt_en = 1;
        pulse_start(); send("R5", 8'hC2, 1, 1); result("R5", 0, 7'h61);
        gcall_en = 0; alert_en = 0; host_en = 0; dflt_en = 0;

        // R7 / R8 10-bit write then read
        own1_ten = 1; own1_addr = 10'h2A5;
        pulse_start();
        send("R7", 8'hF4, 1, 0);
        send("R7", 8'hA5, 1, 1);
        result("R7", 0, 7'h7A);
        pulse_rstart();
        send("R8", 8'hF5, 1, 1);
        result("R8", 1, 7'h7A);
        pulse_stop();
        pulse_start();
        send("R8", 8'hF5, 0, 0);             // ownership cleared by stop/start
        pulse_start();
        send("R7", 8'hF4, 1, 0);
        send("R7", 8'hA4, 0, 0);

        // R9 start and stop discard a pending header
        pulse_start(); send("R9", 8'hF4, 1, 0);
        pulse_start(); send("R9", 8'hA5, 0, 0);
        pulse_start(); send("R9", 8'hF4, 1, 0);
        pulse_stop();  send("R9", 8'hA5, 0, 0);

        // R10 10-bit code wins over an equal 7-bit address
        own2_en = 1; own2_addr = 7'h52; own2_mask = 3'd0;
        pulse_start();
        send("R10", 8'hF4, 1, 0);
        send("R10", 8'hA5, 1, 1);
        result("R10", 0, 7'h7A);
        pulse_stop();
        own2_en = 0;

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule